// File: doc/BRIEF.md
# Indexed RTC register and RAM access port

This block is the host-facing register front end of a real-time clock. The host never addresses a location directly. It first writes an index byte to the index port. It then reads or writes the chosen location through the data port. The index covers fourteen fixed locations and a block of general-purpose RAM bytes that comes after them.

Indices 0x00 to 0x09 hold time and alarm bytes, and 0x0A to 0x0D are control registers A to D. The RAM starts at 0x0E and is 50 bytes long by default, so the last implemented index is 0x3F. The time counters and the periodic divider live in separate blocks. Those blocks deliver single-cycle event pulses and an update-in-progress level to this block, and they take the contents of control registers A and B from its outputs.

Register C collects the three event flags. It presents a summary request bit that depends on which enables are set, and a read of register C clears the flags. The active-low interrupt output follows that summary bit.

Top module: `rtc_regport`

## Requirements
- R1: After a synchronous active-low reset, the following values hold: index 0, registers A and B zero, every time, alarm and RAM byte zero, `rdata` 0x00 and `irq_n` high.
- R2: A strobe on `idx_we` loads `wdata` as the index. A strobe on `data_we` stores `wdata` at the indexed time, alarm or RAM location (0x00 to 0x09, 0x0E to 0x3F). A strobe on `data_re` places the indexed byte on `rdata` in the next cycle, and `rdata` then holds it until the next read.
- R3: Register A (index 0x0A) bits 6..0 are writable and drive `ctrl_a`. Bit 7 reads as the live `uip_in` level, and host writes to bit 7 have no effect.
- R4: Register B (index 0x0B) is a full read/write byte that drives `ctrl_b`. Its bit 4, bit 5 and bit 6 enable the update-end, alarm and periodic interrupts.
- R5: In register C (index 0x0C), bit 4, bit 5 and bit 6 latch pulses on `upd_evt`, `alm_evt` and `per_evt`. Bits 3..0 read as zero.
- R6: Register C bit 7 is the OR of each event flag ANDed with its register B enable. `irq_n` is the inverse of that bit.
- R7: A read of register C returns its current value and clears all three flags. An event that arrives in the same cycle as the read is still latched.
- R8: Host writes to register C and register D change nothing.
- R9: Register D (index 0x0D) reads 0x80: the valid bit 7 is set by reset and the other bits are zero.
- R10: An index of 0x40 or above reads 0x00, and a data write at such an index alters no location.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| idx_we | input | 1 | Load `wdata` into the index register |
| data_we | input | 1 | Write `wdata` to the indexed location |
| data_re | input | 1 | Read the indexed location onto `rdata` |
| wdata | input | 8 | Host write byte (index or data) |
| rdata | output | 8 | Byte returned by the last read |
| uip_in | input | 1 | Update-in-progress level from the time counters |
| upd_evt | input | 1 | Update-end event pulse |
| alm_evt | input | 1 | Alarm match event pulse |
| per_evt | input | 1 | Periodic event pulse |
| ctrl_a | output | 7 | Register A bits 6..0 (rate and divider selection) |
| ctrl_b | output | 8 | Register B contents |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
Each registered result is due one cycle after the clock edge that samples its stimulus. A new index applies to the next data access. Read data appears on `rdata` in the cycle after the read strobe. An event flag, and any change that flag makes to `irq_n`, shows one cycle after the pulse. A register B write changes `irq_n` in the cycle after the write. The bench keeps a behavioural model that is updated on the rising edge from the same inputs. It compares `rdata`, `irq_n`, `ctrl_a` and `ctrl_b` on every falling edge, and each directed read is sampled on the falling edge after the read strobe has been taken.

// File: rtl/rtc_regport_pkg.sv
// Package: shared widths, fixed location indices and the decode select type
// for the indexed RTC register port. Assumes byte-wide host data.
package rtc_regport_pkg;
    localparam int unsigned BYTE_W     = 8;
    localparam int unsigned FIXED_LOCS = 14;
    localparam logic [BYTE_W-1:0] LOC_A = 8'h0A;
    localparam logic [BYTE_W-1:0] LOC_B = 8'h0B;
    localparam logic [BYTE_W-1:0] LOC_C = 8'h0C;
    localparam logic [BYTE_W-1:0] LOC_D = 8'h0D;

    typedef enum logic [2:0] {
        SEL_STORE,
        SEL_A,
        SEL_B,
        SEL_C,
        SEL_D,
        SEL_NONE
    } sel_e;
endpackage

// File: rtl/rtc_index_decode.sv
// Module: rtc_index_decode
// Maps the host index byte to a target select and a byte-store address.
// Assumes N_LOC <= 2**BYTE_W. Indices at or above N_LOC select nothing.
module rtc_index_decode
    import rtc_regport_pkg::*;
#(
    parameter int unsigned N_LOC = 64,
    localparam int unsigned AW   = $clog2(N_LOC)
) (
    input  logic [BYTE_W-1:0] idx,
    output sel_e              sel,
    output logic [AW-1:0]     store_addr
);
    // Classify the index into control register, byte store or out of range.
    always_comb begin
        if (32'(idx) >= N_LOC)  sel = SEL_NONE;
        else if (idx == LOC_A)  sel = SEL_A;
        else if (idx == LOC_B)  sel = SEL_B;
        else if (idx == LOC_C)  sel = SEL_C;
        else if (idx == LOC_D)  sel = SEL_D;
        else                    sel = SEL_STORE;
    end

    assign store_addr = idx[AW-1:0];
endmodule

// File: rtl/rtc_byte_store.sv
// Module: rtc_byte_store
// Flat byte array that holds the time, alarm and RAM bytes. One write port and
// one combinational read port. Cleared by the synchronous reset. Assumes the
// decoder keeps addresses below DEPTH.
module rtc_byte_store
    import rtc_regport_pkg::*;
#(
    parameter int unsigned DEPTH = 64,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [AW-1:0]     addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata
);
    logic [BYTE_W-1:0] mem [DEPTH];

    // Clear every byte on reset and otherwise store on a write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[addr] <= wdata;
        end
    end

    assign rdata = mem[addr];

    // R2
    store_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (rdata == $past(wdata)) || (addr != $past(addr)));
endmodule

// File: rtl/rtc_flag_reg.sv
// Module: rtc_flag_reg
// Event flag register. Each bit sets on its event pulse and all bits clear on
// a clear strobe (a host read). A set that coincides with a clear wins. Also
// forms the summary request from the flags and their enables.
module rtc_flag_reg #(
    parameter int unsigned N_EVT = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_EVT-1:0] evt,
    input  logic [N_EVT-1:0] en,
    input  logic             clr,
    output logic [N_EVT-1:0] flags,
    output logic             irqf
);
    // Latch event pulses and clear on a read of the flag register.
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= (clr ? '0 : flags) | evt;
    end

    assign irqf = |(flags & en);

    // R5
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt != '0) |=> ((flags & $past(evt)) == $past(evt)));
    // R5
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && evt == '0) |=> $stable(flags));
    // R7
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && evt == '0) |=> (flags == '0));
endmodule

// File: rtl/rtc_regport.sv
// Module: rtc_regport (top)
// Indexed host port for an RTC: index register, control registers A to D,
// time/alarm/RAM byte store and the interrupt request. Assumes the host raises
// at most one of idx_we, data_we and data_re per cycle, and that event inputs
// are single-cycle pulses.
module rtc_regport
    import rtc_regport_pkg::*;
#(
    parameter int unsigned RAM_BYTES = 50
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              idx_we,
    input  logic              data_we,
    input  logic              data_re,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    input  logic              uip_in,
    input  logic              upd_evt,
    input  logic              alm_evt,
    input  logic              per_evt,
    output logic [6:0]        ctrl_a,
    output logic [BYTE_W-1:0] ctrl_b,
    output logic              irq_n
);
    localparam int unsigned N_LOC = FIXED_LOCS + RAM_BYTES;
    localparam int unsigned AW    = $clog2(N_LOC);
    localparam int unsigned N_EVT = 3;

    logic [BYTE_W-1:0] idx_q;
    sel_e              sel;
    logic [AW-1:0]     saddr;
    logic [BYTE_W-1:0] store_rd;
    logic [6:0]        a_q;
    logic [BYTE_W-1:0] b_q;
    logic [N_EVT-1:0]  flags;
    logic              irqf;
    logic              vrt_q;
    logic [BYTE_W-1:0] rd_val;
    logic [BYTE_W-1:0] rdata_q;

    rtc_index_decode #(.N_LOC(N_LOC)) u_dec (
        .idx        (idx_q),
        .sel        (sel),
        .store_addr (saddr)
    );

    rtc_byte_store #(.DEPTH(N_LOC)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (data_we && sel == SEL_STORE),
        .addr  (saddr),
        .wdata (wdata),
        .rdata (store_rd)
    );

    rtc_flag_reg #(.N_EVT(N_EVT)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .evt   ({per_evt, alm_evt, upd_evt}),
        .en    (b_q[6:4]),
        .clr   (data_re && sel == SEL_C),
        .flags (flags),
        .irqf  (irqf)
    );

    // Index register: loaded by the index strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)      idx_q <= '0;
        else if (idx_we) idx_q <= wdata;
    end

    // Control registers A (low seven bits) and B: host-writable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q <= '0;
            b_q <= '0;
        end else if (data_we) begin
            if (sel == SEL_A) a_q <= wdata[6:0];
            if (sel == SEL_B) b_q <= wdata;
        end
    end

    // Valid bit: set by reset, no monitoring input can clear it.
    always_ff @(posedge clk) begin
        if (!rst_n) vrt_q <= 1'b1;
    end

    // Read multiplexer over every decoded target.
    always_comb begin
        case (sel)
            SEL_A:     rd_val = {uip_in, a_q};
            SEL_B:     rd_val = b_q;
            SEL_C:     rd_val = {irqf, flags, 4'b0000};
            SEL_D:     rd_val = {vrt_q, 7'b0000000};
            SEL_STORE: rd_val = store_rd;
            default:   rd_val = '0;
        endcase
    end

    // Read data register: captured on the read strobe, held otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)       rdata_q <= '0;
        else if (data_re) rdata_q <= rd_val;
    end

    assign rdata  = rdata_q;
    assign ctrl_a = a_q;
    assign ctrl_b = b_q;
    assign irq_n  = ~irqf;

    // R3
    uip_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_re && sel == SEL_A) |=> (rdata[7] == $past(uip_in)));
    // R8
    ro_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_we && (sel == SEL_C || sel == SEL_D)) |=> ($stable(ctrl_a) && $stable(ctrl_b)));
    // R9
    valid_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_re && sel == SEL_D) |=> (rdata == 8'h80));
    // R10
    oor_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_re && sel == SEL_NONE) |=> (rdata == 8'h00));
    // R5
    c_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_re && sel == SEL_C) |=> (rdata[3:0] == 4'h0));
endmodule

// File: tb/tb_rtc_regport.sv
module tb_rtc_regport;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       idx_we = 0, data_we = 0, data_re = 0;
    logic [7:0] wdata = 0;
    logic [7:0] rdata;
    logic       uip_in = 0, upd_evt = 0, alm_evt = 0, per_evt = 0;
    logic [6:0] ctrl_a;
    logic [7:0] ctrl_b;
    logic       irq_n;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;

    rtc_regport dut (
        .clk(clk), .rst_n(rst_n), .idx_we(idx_we), .data_we(data_we),
        .data_re(data_re), .wdata(wdata), .rdata(rdata), .uip_in(uip_in),
        .upd_evt(upd_evt), .alm_evt(alm_evt), .per_evt(per_evt),
        .ctrl_a(ctrl_a), .ctrl_b(ctrl_b), .irq_n(irq_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural reference model
    int         m_mem [64];
    int         m_idx, m_a, m_b, m_rdata;
    bit         m_fu, m_fa, m_fp;

    function automatic bit m_irqf();
        return (m_fu && m_b[4]) || (m_fa && m_b[5]) || (m_fp && m_b[6]);
    endfunction

    function automatic int m_value(int i);
        if (i >= 64)  return 0;
        if (i == 10)  return (int'(uip_in) << 7) | m_a;
        if (i == 11)  return m_b;
        if (i == 12)  return (int'(m_irqf()) << 7) | (int'(m_fp) << 6) | (int'(m_fa) << 5) | (int'(m_fu) << 4);
        if (i == 13)  return 8'h80;
        return m_mem[i];
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_mem[i]) m_mem[i] = 0;
            m_idx = 0; m_a = 0; m_b = 0; m_rdata = 0;
            m_fu = 0; m_fa = 0; m_fp = 0;
        end else begin
            int cur;
            cur = m_idx;
            if (data_re) begin
                m_rdata = m_value(cur);
                if (cur == 12) begin m_fu = 0; m_fa = 0; m_fp = 0; end
            end
            if (data_we && cur < 64) begin
                if (cur == 10)      m_a = int'(wdata) & 8'h7F;
                else if (cur == 11) m_b = int'(wdata);
                else if (cur != 12 && cur != 13) m_mem[cur] = int'(wdata);
            end
            if (idx_we) m_idx = int'(wdata);
            if (upd_evt) m_fu = 1;
            if (alm_evt) m_fa = 1;
            if (per_evt) m_fp = 1;
        end
    end

    task automatic chk(string tag, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("[TB] FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // Every-cycle comparison against the model, away from the rising edge
    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            chk("R2 rdata", int'(rdata), m_rdata);
            chk("R6 irq_n", int'(irq_n), int'(!m_irqf()));
            chk("R3 ctrl_a", int'(ctrl_a), m_a);
            chk("R4 ctrl_b", int'(ctrl_b), m_b);
        end
        if (cycles > WATCHDOG) begin
            n_tests++; n_fail++;
            $display("[TB] FAIL watchdog: actual %0d cycles expected below %0d", cycles, WATCHDOG);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic set_idx(int i);
        idx_we = 1; wdata = 8'(i); tick(); idx_we = 0;
    endtask

    task automatic wr(int i, int v);
        set_idx(i);
        data_we = 1; wdata = 8'(v); tick(); data_we = 0;
    endtask

    task automatic rd(int i, output int v);
        set_idx(i);
        data_re = 1; tick(); data_re = 0;
        v = int'(rdata);
    endtask

    task automatic pulse(bit u, bit a, bit p);
        upd_evt = u; alm_evt = a; per_evt = p; tick();
        upd_evt = 0; alm_evt = 0; per_evt = 0;
    endtask

    initial begin
        int v;
        repeat (3) tick();
        // R1 reset state, observed during reset
        chk("R1 rdata", int'(rdata), 0);
        chk("R1 irq_n", int'(irq_n), 1);
        chk("R1 ctrl", int'({ctrl_a, ctrl_b}), 0);
        rst_n = 1; tick();
        rd(8'h05, v); chk("R1 alarm byte", v, 0);
        rd(8'h3F, v); chk("R1 ram byte", v, 0);
        // R9
        rd(8'h0D, v); chk("R9 reg D", v, 8'h80);
        // R2 round trips
        wr(8'h00, 8'h59); wr(8'h09, 8'h99); wr(8'h0E, 8'hA5); wr(8'h3F, 8'h3C);
        rd(8'h00, v); chk("R2 idx 00", v, 8'h59);
        rd(8'h09, v); chk("R2 idx 09", v, 8'h99);
        rd(8'h0E, v); chk("R2 idx 0E", v, 8'hA5);
        rd(8'h3F, v); chk("R2 idx 3F", v, 8'h3C);
        tick(); tick(); chk("R2 rdata held", int'(rdata), 8'h3C);
        // R3
        uip_in = 0; wr(8'h0A, 8'hFF);
        rd(8'h0A, v); chk("R3 uip low", v, 8'h7F);
        uip_in = 1; rd(8'h0A, v); chk("R3 uip high", v, 8'hFF);
        uip_in = 0; wr(8'h0A, 8'h26);
        rd(8'h0A, v); chk("R3 reg A", v, 8'h26);
        // R4
        wr(8'h0B, 8'h8E); rd(8'h0B, v); chk("R4 reg B", v, 8'h8E);
        chk("R4 ctrl_b", int'(ctrl_b), 8'h8E);
        wr(8'h0B, 8'h00);
        // R5: flags latch with no enables, no request
        pulse(1, 0, 0); pulse(0, 1, 0); pulse(0, 0, 1);
        chk("R5 irq_n no enable", int'(irq_n), 1);
        rd(8'h0C, v); chk("R5 reg C flags", v, 8'h70);
        // R7 cleared by the read
        rd(8'h0C, v); chk("R7 reg C cleared", v, 8'h00);
        // R6 alarm-only enable
        wr(8'h0B, 8'h20);
        pulse(1, 0, 0); chk("R6 masked event", int'(irq_n), 1);
        pulse(0, 1, 0); chk("R6 enabled event", int'(irq_n), 0);
        rd(8'h0C, v); chk("R6 reg C summary", v, 8'hB0);
        chk("R7 irq_n released", int'(irq_n), 1);
        // R6 enable write alone raises request on a pending flag
        pulse(0, 0, 1); chk("R6 periodic masked", int'(irq_n), 1);
        wr(8'h0B, 8'h60); chk("R6 enable after flag", int'(irq_n), 0);
        rd(8'h0C, v); chk("R6 reg C periodic", v, 8'hC0);
        // R7 event coinciding with the read survives
        pulse(0, 1, 0);
        set_idx(8'h0C);
        data_re = 1; per_evt = 1; tick(); data_re = 0; per_evt = 0;
        chk("R7 read before clear", int'(rdata), 8'hA0);
        chk("R7 coincident irq", int'(irq_n), 0);
        rd(8'h0C, v); chk("R7 coincident kept", v, 8'hC0);
        // R8 writes to C and D
        pulse(1, 0, 0);
        wr(8'h0C, 8'hFF); wr(8'h0D, 8'h00);
        rd(8'h0D, v); chk("R8 reg D unchanged", v, 8'h80);
        rd(8'h0C, v); chk("R8 reg C unchanged", v, 8'h10);
        rd(8'h0B, v); chk("R8 reg B unchanged", v, 8'h60);
        rd(8'h0E, v); chk("R8 ram unchanged", v, 8'hA5);
        // R10 out-of-range indices
        wr(8'h4E, 8'h55); wr(8'hFF, 8'h11); wr(8'h40, 8'h77);
        rd(8'h4E, v); chk("R10 read 4E", v, 0);
        rd(8'h40, v); chk("R10 read 40", v, 0);
        rd(8'h0E, v); chk("R10 alias 0E", v, 8'hA5);
        rd(8'h3F, v); chk("R10 alias 3F", v, 8'h3C);
        rd(8'h00, v); chk("R10 alias 00", v, 8'h59);
        tick();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule